// File: doc/BRIEF.md
# Programmable-Order CIC Comb Cascade

This block is the low-rate differentiator half of a cascaded integrator-comb decimator. Each time the decimation strobe fires, it takes one 26-bit sample from the upstream decimation register and passes it through a chain of five differentiator stages. A differentiator subtracts the sample it held from the previous strobe from the current one. It then discards low-order bits, so the datapath narrows from 26 bits down to 19 bits across the chain.

The filter order is programmable. An order value of k makes stages 1 to k differentiate. The remaining stages hold a zero delay value, so the data passes through them unchanged apart from their truncation. A bypass input turns off every stage whatever the order. The 19-bit chain result is rounded to 16 bits with saturation and held in an output register for the downstream FIR stage.

Top module: `cic_comb_cascade`

## Requirements
- R1: After the asynchronous active-low reset, `dout` is 0 and every stage holds a zero delay value, so the first strobed sample is not differenced against any earlier data.
- R2: An enabled stage outputs its current input minus the input it accepted at the previous strobe, and it loads the current input as the new delay value on each strobe.
- R3: An `order` value k enables stages 1 through k. A value of 0 enables none, and any value of 5 or above enables all five.
- R4: A disabled stage has a delay value of zero from the moment it is disabled, so its input passes straight to its truncation. A stage that is enabled again starts from a zero history.
- R5: While `bypass` is high, all five stages behave as disabled regardless of `order`.
- R6: The stage output widths are 26, 24, 23, 21 and 19 bits for stages 1 to 5. Each stage subtracts in two's complement at its input width, with wraparound, and then drops least significant bits by an arithmetic shift to reach its output width.
- R7: The 19-bit chain result is rounded to 16 bits by adding 4 and shifting right arithmetically by 3. A result above 32767 saturates to 32767, and one below -32768 saturates to -32768.
- R8: `dout` loads the rounded result on the clock edge where `dec_stb` is high and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_stb | input | 1 | Decimation strobe; one sample is accepted per high cycle |
| din | input | 26 | Two's-complement sample from the decimation register |
| order | input | 3 | Number of active differentiator stages |
| bypass | input | 1 | Forces all stages to pass-through |
| dout | output | 16 | Rounded, saturated two's-complement result |

## Verification
The assertions assume that `din`, `order` and `bypass` are valid and held steady on every clock edge where `dec_stb` is high. They also assume that an order or bypass change lasts at least one edge, which is the edge on which a disabled stage clears its register. The stimulus meets these assumptions in the following way:
- Inputs change only at the falling edge.
- `order` and `bypass` change together with a strobe.
- Each strobe is followed by at least one idle cycle with a different `din`.

That idle cycle also shows that non-strobe edges neither capture a sample nor change the output.

// File: rtl/cic_comb_pkg.sv
package cic_comb_pkg;

  localparam int NSTAGE = 5;
  localparam int IN_W   = 26;
  localparam int OUT_W  = 16;

  // width of chain node k (node 0 is the input, node k the output of stage k)
  function automatic int node_w(int k);
    case (k)
      0, 1:    return 26;
      2:       return 24;
      3:       return 23;
      4:       return 21;
      default: return 19;
    endcase
  endfunction

  // bit offset of node k inside the packed chain bus
  function automatic int node_off(int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += node_w(i);
    return s;
  endfunction

endpackage

// File: rtl/comb_order_dec.sv
module comb_order_dec #(
  parameter int ORD_W  = 3,
  parameter int NSTAGE = 5
) (
  input  logic [ORD_W-1:0]  order,
  input  logic              bypass,
  output logic [NSTAGE:1]   stage_en
);

  always_comb begin
    for (int k = 1; k <= NSTAGE; k++) begin
      stage_en[k] = !bypass && (32'(order) >= k);
    end
  end

endmodule

// File: rtl/comb_stage.sv
module comb_stage #(
  parameter int SRC_W = 26,
  parameter int DST_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic [SRC_W-1:0] din,
  output logic [DST_W-1:0] dout
);

  localparam int DROP = SRC_W - DST_W;

  logic [SRC_W-1:0] dly_q;
  logic [SRC_W-1:0] dly_d;
  logic [SRC_W-1:0] dly_eff;
  logic [SRC_W-1:0] diff;

  // next-state: cleared while disabled, loaded on strobe
  always_comb begin
    if (!en)      dly_d = '0;
    else if (stb) dly_d = din;
    else          dly_d = dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign dly_eff = en ? dly_q : '0;
  assign diff    = din - dly_eff;

  generate
    if (DROP > 0) begin : g_trunc
      logic unused_lsb;
      assign unused_lsb = ^diff[DROP-1:0];
      assign dout = diff[SRC_W-1:DROP];
    end else begin : g_full
      assign dout = diff;
    end
  endgenerate

  // R4: a disabled stage holds zero history
  a_r4_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dly_q == '0));

  // R2: strobe on an enabled stage captures the current input
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> (dly_q == $past(din)));

endmodule

// File: rtl/comb_round.sv
module comb_round #(
  parameter int IN_W  = 19,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int DROP = IN_W - OUT_W;
  localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP-1);

  logic [IN_W:0]  sum;
  logic [OUT_W:0] q;
  logic           unused_lsb;

  assign sum        = {din[IN_W-1], din} + HALF;
  assign q          = sum[IN_W:DROP];
  assign unused_lsb = ^sum[DROP-1:0];

  always_comb begin
    if (q[OUT_W] != q[OUT_W-1])
      dout = q[OUT_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    else
      dout = q[OUT_W-1:0];
  end

endmodule

// File: rtl/cic_comb_cascade.sv
module cic_comb_cascade
  import cic_comb_pkg::*;
#(
  parameter int ORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_stb,
  input  logic [IN_W-1:0]   din,
  input  logic [ORD_W-1:0]  order,
  input  logic              bypass,
  output logic [OUT_W-1:0]  dout
);

  localparam int BUS_W = node_off(NSTAGE + 1);
  localparam int RES_W = node_w(NSTAGE);

  logic [BUS_W-1:0]  node_bus;
  logic [NSTAGE:1]   stage_en;
  logic [OUT_W-1:0]  rnd;
  logic [OUT_W-1:0]  dout_q;
  logic [OUT_W-1:0]  dout_d;

  comb_order_dec #(.ORD_W(ORD_W), .NSTAGE(NSTAGE)) u_dec (
    .order    (order),
    .bypass   (bypass),
    .stage_en (stage_en)
  );

  assign node_bus[node_w(0)-1:0] = din;

  generate
    for (genvar k = 1; k <= NSTAGE; k++) begin : g_stage
      comb_stage #(.SRC_W(node_w(k-1)), .DST_W(node_w(k))) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (dec_stb),
        .en    (stage_en[k]),
        .din   (node_bus[node_off(k-1) +: node_w(k-1)]),
        .dout  (node_bus[node_off(k) +: node_w(k)])
      );
    end
  endgenerate

  comb_round #(.IN_W(RES_W), .OUT_W(OUT_W)) u_round (
    .din  (node_bus[node_off(NSTAGE) +: RES_W]),
    .dout (rnd)
  );

  always_comb begin
    dout_d = dec_stb ? rnd : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

  // R8: output holds between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_stb |=> $stable(dout));

  // R5: bypass disables every stage
  a_r5_bypass_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (stage_en == '0));

endmodule

// File: tb/cic_comb_cascade_bench.sv
module cic_comb_cascade_bench;

  logic        clk;
  logic        rst_n;
  logic        dec_stb;
  logic [25:0] din;
  logic [2:0]  order;
  logic        bypass;
  logic [15:0] dout;

  int n_chk;
  int n_fail;
  longint prev [1:5];
  longint exp_q;
  logic [31:0] lfsr;
  bit done;

  cic_comb_cascade u_cic_comb_cascade (
    .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .din(din),
    .order(order), .bypass(bypass), .dout(dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int wdt(int k);
    case (k)
      0, 1: return 26;
      2: return 24;
      3: return 23;
      4: return 21;
      default: return 19;
    endcase
  endfunction

  function automatic longint wrap(longint v, int w);
    longint m;
    m = v & ((64'sd1 <<< w) - 1);
    if (m >= (64'sd1 <<< (w-1))) m = m - (64'sd1 <<< w);
    return m;
  endfunction

  // arithmetic model of one strobe; updates prev[]
  function automatic longint model(longint xin, int ord, bit byp);
    longint x, d, r;
    x = xin;
    for (int k = 1; k <= 5; k++) begin
      if (!byp && ord >= k) begin
        d = x - prev[k];
        prev[k] = x;
      end else begin
        d = x;
        prev[k] = 0;
      end
      d = wrap(d, wdt(k-1));
      x = d >>> (wdt(k-1) - wdt(k));
    end
    r = (x + 4) >>> 3;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(string tag, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: dout=%0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic string tag_of(int ord, bit byp);
    if (byp) return "R5";
    if (ord == 0) return "R4";
    if (ord >= 5) return "R2";
    return "R3";
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // one strobed sample, then one idle cycle with a different din
  task automatic sample(longint x, int ord, bit byp, string tag);
    longint held;
    @(negedge clk);
    din = x[25:0];
    order = ord[2:0];
    bypass = byp;
    dec_stb = 1'b1;
    exp_q = model(x, ord, byp);
    @(negedge clk);
    dec_stb = 1'b0;
    check(tag, longint'($signed(dout)), exp_q);
    held = longint'($signed(dout));
    step_lfsr();
    din = lfsr[25:0];
    @(negedge clk);
    check("R8", longint'($signed(dout)), held);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    lfsr = 32'hACE1_1234;
    for (int k = 1; k <= 5; k++) prev[k] = 0;
    rst_n = 1'b0; dec_stb = 1'b0; din = '0; order = 3'd5; bypass = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", longint'($signed(dout)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first sample after reset, full order, sees zero history
    sample(64'sd1_000_000, 5, 1'b0, "R1");
    // R6: wraparound at stage 1 width and saturation through bypass
    sample(64'sd33554431, 1, 1'b0, "R6");
    sample(-64'sd33554432, 1, 1'b0, "R6");
    sample(64'sd33554431, 0, 1'b1, "R7");
    sample(-64'sd33554432, 0, 1'b1, "R7");
    sample(64'sd1000, 0, 1'b1, "R7");
    sample(-64'sd1000, 0, 1'b1, "R7");
    // R3: impulse response at each order
    for (int o = 1; o <= 5; o++) begin
      sample(64'sd4_000_000, o, 1'b0, "R3");
      for (int j = 0; j < 6; j++) sample(0, o, 1'b0, "R3");
    end
    // sweep over all order/bypass settings with pseudo-random data
    for (int b = 0; b < 2; b++) begin
      for (int o = 0; o < 8; o++) begin
        for (int j = 0; j < 12; j++) begin
          step_lfsr();
          sample(longint'($signed(lfsr[25:0])), o, b[0], tag_of(o, b[0]));
        end
      end
    end
    // R4: drop order then restore; re-enabled stages start empty
    sample(64'sd123456, 5, 1'b0, "R4");
    sample(64'sd654321, 2, 1'b0, "R4");
    sample(64'sd222222, 5, 1'b0, "R4");
    sample(64'sd333333, 5, 1'b0, "R4");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: dout=%0d expected completion", dout);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule